// File: doc/BRIEF.md
# Coprocessor Host Port

This block is the host-facing register port of a coprocessor link. The host reaches it through a byte-wide synchronous bus: four control and status registers plus a data window that is several bytes wide. Words move from the host to the coprocessor through a transmit holding register. Words move the other way through a receive holding register. A status flag tracks each direction, and either flag can raise a request line to the host.

On the coprocessor side, each direction is a valid/ready stream. The outbound stream presents a word while the transmit holding register is full. If ready is held low, the word and valid stay unchanged and the host keeps seeing transmit-empty clear. The inbound stream is accepted only while the receive holding register is empty, so a second word waits at the coprocessor until the host has read the last byte of the first.

The port also does three things outside the data path. It passes two flag bits in each direction. It latches a command vector that stays locked until the coprocessor acknowledges it. It offers an init command that empties both directions in one cycle.

Top module: `hpi_host_port`

## Requirements
- R1: Register slots are decoded from host_addr: 0 control, 1 command vector, 2 status (read-only), 3 interrupt vector. After reset the values are: control reads 0x00, command vector reads 0x00, interrupt vector reads 0x0F and is freely writable, and status reads 0x06 while cp_rx_empty is high.
- R2: Host writes to addresses 4..7 load the data bytes, most significant byte at address 4. Writing address 7 (the least significant byte) clears transmit-empty (status bit 1). While transmit-empty is clear, cp_tx_valid is high and cp_tx_data holds the word. A cycle with cp_tx_valid and cp_tx_ready both high sets transmit-empty again. While ready is low, the word is held stable.
- R3: cp_rx_ready is high exactly while receive-full (status bit 0) is clear. An accepted word sets receive-full. Host reads of addresses 4..7 return that word, most significant byte first. A read of address 7 clears receive-full.
- R4: Status bit 2 (transmitter ready) is 1 only when transmit-empty is set and cp_rx_empty is high.
- R5: host_req and status bit 7 are high when (control bit 0 AND receive-full) OR (control bit 1 AND transmit-empty).
- R6: A write to the command vector register while its bit 7 is clear loads the vector number (bits 4:0) and bit 7. While bit 7 is set, cmd_req is high, cmd_vec shows the vector, and further writes are ignored. cmd_ack clears bit 7.
- R7: Writing control with bit 7 set makes transmit-empty 1 and receive-full 0 on the next cycle. This takes priority over a concurrent stream transfer. Control bit 7 reads back 1 for exactly that next cycle and 0 after it.
- R8: Control bits 4:3 drive host_flags and control bits 6:5 drive host_mode. cp_flags appears in status bits 4:3. Status bit 6 is 1 when host_mode is nonzero, and status bit 5 reads 0.
- R9: If the host writes address 7 in the same cycle that the coprocessor takes the pending word, transmit-empty stays clear and the new word is presented next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (read side effects) |
| host_addr | input | 3 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |
| host_req | output | 1 | Request to the host |
| host_flags | output | 2 | Flags from host to coprocessor |
| host_mode | output | 2 | Host mode field |
| cp_tx_valid | output | 1 | Outbound word valid |
| cp_tx_ready | input | 1 | Coprocessor takes outbound word |
| cp_tx_data | output | 32 | Outbound word |
| cp_rx_valid | input | 1 | Inbound word valid |
| cp_rx_ready | output | 1 | Port can accept inbound word |
| cp_rx_data | input | 32 | Inbound word |
| cp_rx_empty | input | 1 | Coprocessor's own receive register is empty |
| cp_flags | input | 2 | Flags from coprocessor to host |
| cmd_req | output | 1 | Command vector pending |
| cmd_vec | output | 5 | Pending vector number |
| cmd_ack | input | 1 | Coprocessor acknowledges the vector |

## Verification
Two events can land on the transmit-empty flag in the same cycle: the coprocessor taking the held word, and the host writing the least significant byte of the next word. The bench raises cp_tx_ready during the same clock as the host write to address 7. It then judges that valid stays high and that cp_tx_data carries the new byte. The init command is likewise issued while a transmit word is pending and a receive word is held. The bench expects both flags to be in their empty state one cycle later, with the init bit visible for just that cycle.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  localparam int REG_SLOTS = 4;

  localparam int SLOT_CTRL = 0;
  localparam int SLOT_CVR  = 1;
  localparam int SLOT_STAT = 2;
  localparam int SLOT_IVR  = 3;

  localparam logic [7:0] IVR_RESET = 8'h0F;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] hflag;
    logic       tx_ie;
    logic       rx_ie;
  } ctrl_t;
endpackage

// File: rtl/hpi_ctrl_regs.sv
module hpi_ctrl_regs
  import hpi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wr_cvr,
  input  logic       wr_ivr,
  input  logic [7:0] wdata,
  input  logic       cmd_ack,
  output ctrl_t      ctrl,
  output logic       init_pulse,
  output logic       cvr_hc,
  output logic [4:0] cvr_vec,
  output logic [7:0] ivr
);
  logic unused_bits;
  assign unused_bits = ^{wdata[2], wdata[6:5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= '0;
      init_pulse <= 1'b0;
    end else begin
      init_pulse <= wr_ctrl & wdata[7];
      if (wr_ctrl) begin
        ctrl.rx_ie <= wdata[0];
        ctrl.tx_ie <= wdata[1];
        ctrl.hflag <= wdata[4:3];
        ctrl.mode  <= wdata[6:5];
      end
    end
  end

  // Vector locked while the command bit is pending.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cvr_hc  <= 1'b0;
      cvr_vec <= '0;
    end else if (wr_cvr && !cvr_hc) begin
      cvr_hc  <= wdata[7];
      cvr_vec <= wdata[4:0];
    end else if (cmd_ack) begin
      cvr_hc  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ivr <= IVR_RESET;
    else if (wr_ivr) ivr <= wdata;
  end
endmodule

// File: rtl/hpi_tx_path.sv
module hpi_tx_path #(
  parameter int DATA_BYTES = 4,
  localparam int WORD_W = 8 * DATA_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DATA_BYTES-1:0] lane_we,
  input  logic [7:0]            wdata,
  input  logic                  init,
  input  logic                  take,
  output logic                  empty,
  output logic [WORD_W-1:0]     word
);
  logic [7:0] lane_q [DATA_BYTES];

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lane_q[b] <= '0;
      else if (lane_we[b]) lane_q[b] <= wdata;
    end
    assign word[8*b +: 8] = lane_q[b];
  end

  // Lane 0 is the least significant byte; its write commits the word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              empty <= 1'b1;
    else if (init)           empty <= 1'b1;
    else if (lane_we[0])     empty <= 1'b0;
    else if (!empty && take) empty <= 1'b1;
  end
endmodule

// File: rtl/hpi_rx_path.sv
module hpi_rx_path #(
  parameter int DATA_BYTES = 4,
  localparam int WORD_W = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              rd_lsb,
  input  logic              init,
  output logic              in_ready,
  output logic              full,
  output logic [WORD_W-1:0] word
);
  logic accept;
  assign in_ready = !full;
  assign accept   = in_valid && !full && !init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      full <= 1'b0;
    else if (init)   full <= 1'b0;
    else if (accept) full <= 1'b1;
    else if (rd_lsb) full <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word <= '0;
    else if (accept) word <= in_data;
  end
endmodule

// File: rtl/hpi_host_port.sv
module hpi_host_port
  import hpi_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  localparam int WORD_W = 8 * DATA_BYTES,
  localparam int ADDR_W = $clog2(REG_SLOTS + DATA_BYTES),
  localparam int LSB_ADDR = REG_SLOTS + DATA_BYTES - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_req,
  output logic [1:0]        host_flags,
  output logic [1:0]        host_mode,
  output logic              cp_tx_valid,
  input  logic              cp_tx_ready,
  output logic [WORD_W-1:0] cp_tx_data,
  input  logic              cp_rx_valid,
  output logic              cp_rx_ready,
  input  logic [WORD_W-1:0] cp_rx_data,
  input  logic              cp_rx_empty,
  input  logic [1:0]        cp_flags,
  output logic              cmd_req,
  output logic [4:0]        cmd_vec,
  input  logic              cmd_ack
);
  ctrl_t                 ctrl;
  logic                  init_q;
  logic                  cvr_hc;
  logic [7:0]            ivr;
  logic                  tx_empty, rx_full;
  logic [WORD_W-1:0]     rx_word;
  logic [DATA_BYTES-1:0] lane_we;
  logic                  in_data_win;
  logic                  wr_init;
  logic [7:0]            status;

  assign in_data_win = host_addr >= ADDR_W'(REG_SLOTS);
  assign wr_init     = host_wr && host_addr == ADDR_W'(SLOT_CTRL) && host_wdata[7];

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_we
    assign lane_we[DATA_BYTES-1-k] = host_wr && host_addr == ADDR_W'(REG_SLOTS + k);
  end

  hpi_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (host_wr && host_addr == ADDR_W'(SLOT_CTRL)),
    .wr_cvr    (host_wr && host_addr == ADDR_W'(SLOT_CVR)),
    .wr_ivr    (host_wr && host_addr == ADDR_W'(SLOT_IVR)),
    .wdata     (host_wdata),
    .cmd_ack   (cmd_ack),
    .ctrl      (ctrl),
    .init_pulse(init_q),
    .cvr_hc    (cvr_hc),
    .cvr_vec   (cmd_vec),
    .ivr       (ivr)
  );

  hpi_tx_path #(.DATA_BYTES(DATA_BYTES)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .lane_we(lane_we),
    .wdata  (host_wdata),
    .init   (wr_init),
    .take   (cp_tx_ready),
    .empty  (tx_empty),
    .word   (cp_tx_data)
  );

  hpi_rx_path #(.DATA_BYTES(DATA_BYTES)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(cp_rx_valid),
    .in_data (cp_rx_data),
    .rd_lsb  (host_rd && host_addr == ADDR_W'(LSB_ADDR)),
    .init    (wr_init),
    .in_ready(cp_rx_ready),
    .full    (rx_full),
    .word    (rx_word)
  );

  assign cp_tx_valid = !tx_empty;
  assign cmd_req     = cvr_hc;
  assign host_flags  = ctrl.hflag;
  assign host_mode   = ctrl.mode;
  assign host_req    = (ctrl.rx_ie && rx_full) || (ctrl.tx_ie && tx_empty);

  assign status = {host_req, |ctrl.mode, 1'b0, cp_flags,
                   tx_empty && cp_rx_empty, tx_empty, rx_full};

  always_comb begin
    host_rdata = '0;
    if (in_data_win) begin
      for (int k = 0; k < DATA_BYTES; k++)
        if (host_addr == ADDR_W'(REG_SLOTS + k))
          host_rdata = rx_word[8*(DATA_BYTES-1-k) +: 8];
    end else begin
      case (int'(host_addr))
        SLOT_CTRL: host_rdata = {init_q, ctrl.mode, ctrl.hflag, 1'b0, ctrl.tx_ie, ctrl.rx_ie};
        SLOT_CVR:  host_rdata = {cvr_hc, 2'b00, cmd_vec};
        SLOT_STAT: host_rdata = status;
        default:   host_rdata = ivr;
      endcase
    end
  end
endmodule

// File: rtl/hpi_host_port_chk.sv
module hpi_host_port_chk #(
  parameter int DATA_BYTES = 4,
  localparam int WORD_W = 8 * DATA_BYTES,
  localparam int ADDR_W = $clog2(4 + DATA_BYTES),
  localparam int LSB_ADDR = 4 + DATA_BYTES - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_wdata,
  input logic              cp_tx_valid,
  input logic              cp_tx_ready,
  input logic [WORD_W-1:0] cp_tx_data,
  input logic              cp_rx_valid,
  input logic              cp_rx_ready,
  input logic              cmd_req,
  input logic [4:0]        cmd_vec,
  input logic              cmd_ack,
  input logic              init_q
);
  logic unused_w;
  assign unused_w = ^host_wdata[6:0];

  logic init_wr, data_wr;
  assign init_wr = host_wr && host_addr == '0 && host_wdata[7];
  assign data_wr = host_wr && host_addr >= ADDR_W'(4);

  p_lsb_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == ADDR_W'(LSB_ADDR)) |=> cp_tx_valid);

  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_tx_valid && !cp_tx_ready && !data_wr && !init_wr) |=> (cp_tx_valid && $stable(cp_tx_data)));

  p_rx_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_rx_valid && cp_rx_ready && !init_wr) |=> !cp_rx_ready);

  p_cmd_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_vec)));

  p_init_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (!cp_tx_valid && cp_rx_ready && init_q));

  p_init_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && !init_wr) |=> !init_q);
endmodule

bind hpi_host_port hpi_host_port_chk #(.DATA_BYTES(DATA_BYTES)) u_chk (.*);

// File: tb/sim_hpi_host_port.sv
module sim_hpi_host_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_req;
  logic [1:0]  host_flags, host_mode;
  logic        cp_tx_valid, cp_tx_ready = 1'b0;
  logic [31:0] cp_tx_data;
  logic        cp_rx_valid = 1'b0, cp_rx_ready;
  logic [31:0] cp_rx_data = '0;
  logic        cp_rx_empty = 1'b1;
  logic [1:0]  cp_flags = '0;
  logic        cmd_req, cmd_ack = 1'b0;
  logic [4:0]  cmd_vec;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpi_host_port u0 (.*);

  // {write, addr, data, expected}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd2, 8'h00, 8'h06}, {1'b0, 3'd0, 8'h00, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'h00}, {1'b0, 3'd3, 8'h00, 8'h0F},
    {1'b1, 3'd3, 8'h5A, 8'h00}, {1'b0, 3'd3, 8'h00, 8'h5A},
    {1'b1, 3'd0, 8'h02, 8'h00}, {1'b0, 3'd2, 8'h00, 8'h86},
    {1'b1, 3'd4, 8'h11, 8'h00}, {1'b1, 3'd5, 8'h22, 8'h00},
    {1'b1, 3'd6, 8'h33, 8'h00}, {1'b1, 3'd7, 8'h44, 8'h00},
    {1'b0, 3'd2, 8'h00, 8'h00}
  };
  localparam string VTAG [NV] = '{"R1", "R1", "R1", "R1", "", "R1", "",
                                  "R5", "", "", "", "", "R2"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    host_addr = a; host_rd = 1'b1;
    #2 v = host_rdata;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic deliver(input logic [31:0] w);
    cp_rx_valid = 1'b1; cp_rx_data = w;
    @(posedge clk); #1;
    cp_rx_valid = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    idle(3);
    rst_n = 1'b1;
    #2;
    chk("R1 reset tx_valid", cp_tx_valid, 0);
    chk("R1 reset rx_ready", cp_rx_ready, 1);
    chk("R1 reset cmd_req", cmd_req, 0);
    chk("R1 reset host_req", host_req, 0);
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][18:16], v);
        chk(VTAG[i], v, VEC[i][7:0]);
      end
    end

    chk("R2 valid", cp_tx_valid, 1);
    chk("R2 word", cp_tx_data, 32'h11223344);
    idle(3);
    chk("R2 backpressure valid", cp_tx_valid, 1);
    chk("R2 backpressure word", cp_tx_data, 32'h11223344);

    // R9: LSB write collides with take
    cp_tx_ready = 1'b1;
    wr(3'd7, 8'h77);
    cp_tx_ready = 1'b0;
    chk("R9 valid kept", cp_tx_valid, 1);
    chk("R9 new word", cp_tx_data, 32'h11223377);

    cp_tx_ready = 1'b1; idle(1); cp_tx_ready = 1'b0;
    chk("R2 take", cp_tx_valid, 0);
    rd(3'd2, v); chk("R2 status after take", v, 8'h86);

    cp_rx_empty = 1'b0;
    rd(3'd2, v); chk("R4 trdy low", v, 8'h82);
    cp_rx_empty = 1'b1;

    wr(3'd0, 8'h01);
    deliver(32'hA1B2C3D4);
    chk("R3 ready low", cp_rx_ready, 0);
    chk("R5 req on rx", host_req, 1);
    rd(3'd2, v); chk("R3 status full", v, 8'h87);
    rd(3'd4, v); chk("R3 msb", v, 8'hA1);
    chk("R3 still full", cp_rx_ready, 0);
    rd(3'd7, v); chk("R3 lsb", v, 8'hD4);
    chk("R3 drained", cp_rx_ready, 1);
    chk("R5 req dropped", host_req, 0);

    wr(3'd1, 8'h93);
    chk("R6 req", cmd_req, 1);
    chk("R6 vec", cmd_vec, 5'h13);
    wr(3'd1, 8'h85);
    chk("R6 locked vec", cmd_vec, 5'h13);
    rd(3'd1, v); chk("R6 readback", v, 8'h93);
    cmd_ack = 1'b1; idle(1); cmd_ack = 1'b0;
    chk("R6 ack clears", cmd_req, 0);
    wr(3'd1, 8'h05);
    chk("R6 no req", cmd_req, 0);
    rd(3'd1, v); chk("R6 plain vec", v, 8'h05);

    wr(3'd7, 8'h55);
    deliver(32'h01020304);
    chk("R7 pre tx", cp_tx_valid, 1);
    chk("R7 pre rx", cp_rx_ready, 0);
    wr(3'd0, 8'h80);
    rd(3'd0, v); chk("R7 init visible", v, 8'h80);
    rd(3'd0, v); chk("R7 init cleared", v, 8'h00);
    chk("R7 tx empty", cp_tx_valid, 0);
    chk("R7 rx empty", cp_rx_ready, 1);
    rd(3'd2, v); chk("R7 status", v, 8'h06);

    cp_flags = 2'b10;
    rd(3'd2, v); chk("R8 cp flags", v, 8'h16);
    wr(3'd0, 8'h78);
    chk("R8 host flags", host_flags, 2'b11);
    chk("R8 host mode", host_mode, 2'b11);
    rd(3'd2, v); chk("R8 dma bit", v, 8'h56);
    cp_flags = 2'b00;

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule